// File: doc/BRIEF.md
# USB Legacy SMI Control and Status Register

This block is a 32-bit configuration register inside a USB 2.0 host controller. It collects the sources that may raise a legacy system-management interrupt (SMI) and drives a single SMI output. Three sources are sticky events: a write to the base address register, a write to the PCI command register, and any change of the OS-owned semaphore bit. Six further sources mirror the host status flags without holding state of their own. Software clears these mirrored sources only in the host status register.

Each source has its own enable bit. The SMI output is a registered level. It is high while at least one source and its enable are both set, and it drops once every enabled source has cleared. Software reaches the register through a simple read/write port with byte enables. The register sits in the suspend power well, so only the suspend-well reset returns it to zero.

Top module: `usb_legacy_smi_reg`

## Requirements
- R1: After reset, a read returns 0x00000000 and `smi_o` is 0.
- R2: A one-cycle `bar_wr_evt` pulse sets bit 31. Bit 31 then stays set until software writes 1 to it with byte enable 3 active.
- R3: A one-cycle `cmd_wr_evt` pulse sets bit 30. Bit 30 is write-1-to-clear through byte lane 3.
- R4: Bit 29 sets on every change of `os_own_sem` in either direction. The change is found against a registered copy of the input, and that copy resets to 0. Bit 29 is write-1-to-clear.
- R5: Bits 21..16 read back the live `hc_sts[5:0]` (bit 21 = async advance, then host system error, frame list rollover, port change, USB error, and bit 16 = USB interrupt). Writes to these bits have no effect.
- R6: Bits 28..22 and 12..6 always read 0, and writes to them have no effect.
- R7: Bits 15..13 enable the sources at bits 31..29. Bits 5..0 enable the sources at bits 21..16, in the same order. All of these bits are read/write. Byte lane 1 writes bits 15..13 and byte lane 0 writes bits 5..0, each only when its byte enable is set.
- R8: At each clock edge, `smi_o` takes the OR of every enable-and-source pair as they stood just before that edge. It therefore falls one cycle after the last enabled source clears.
- R9: If a set event and a write-1-to-clear reach the same sticky bit in the same cycle, the bit stays 1.
- R10: `reg_rdata` takes the register value in the cycle after a `reg_rd` strobe, showing the state before any write in that same cycle. It holds that value until the next strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low suspend-well reset |
| bar_wr_evt | input | 1 | Pulse: the base address register was written |
| cmd_wr_evt | input | 1 | Pulse: the PCI command register was written |
| os_own_sem | input | 1 | Current level of the OS-owned semaphore |
| hc_sts | input | 6 | Host status flags, async advance at bit 5 down to USB interrupt at bit 0 |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_be | input | 4 | Byte enables for the write |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, registered |
| smi_o | output | 1 | SMI request level |

## Verification
The hardest case to reach is the collision on a sticky bit: a source event and a write-1-to-clear of the same bit landing on the same clock edge. The bench drives the event pulse and the clearing write from one task, on the same falling edge. It then reads the bit back and checks that the event survived. A second hard case is the semaphore, which must raise its source on a falling edge as well as a rising one. The bench toggles the semaphore up, clears the bit, toggles it down again, and runs a cycle-accurate model alongside the design that compares `smi_o` and `reg_rdata` on every clock.

// File: rtl/usb_legacy_smi_reg.sv
module usb_legacy_smi_reg #(
  parameter int N_EVT = 3,
  parameter int N_MIR = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bar_wr_evt,
  input  logic             cmd_wr_evt,
  input  logic             os_own_sem,
  input  logic [N_MIR-1:0] hc_sts,
  input  logic             reg_wr,
  input  logic             reg_rd,
  input  logic [3:0]       reg_be,
  input  logic [31:0]      reg_wdata,
  output logic [31:0]      reg_rdata,
  output logic             smi_o
);

  localparam int RSV_HI = 32 - 16 - N_MIR - N_EVT;
  localparam int RSV_LO = 16 - N_EVT - N_MIR;

  logic [N_EVT-1:0] ev_q, ev_set, ev_clr, en_hi;
  logic [N_MIR-1:0] en_lo;
  logic             sem_q, smi_q;
  logic [31:0]      cur, rd_q;

  assign ev_set = {bar_wr_evt, cmd_wr_evt, os_own_sem ^ sem_q};
  assign ev_clr = (reg_wr && reg_be[3]) ? reg_wdata[31 -: N_EVT] : '0;
  assign cur    = {ev_q, {RSV_HI{1'b0}}, hc_sts, en_hi, {RSV_LO{1'b0}}, en_lo};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ev_q  <= '0;
      sem_q <= 1'b0;
      en_hi <= '0;
      en_lo <= '0;
      smi_q <= 1'b0;
      rd_q  <= '0;
    end else begin
      ev_q  <= (ev_q & ~ev_clr) | ev_set;
      sem_q <= os_own_sem;
      if (reg_wr && reg_be[1]) en_hi <= reg_wdata[15 -: N_EVT];
      if (reg_wr && reg_be[0]) en_lo <= reg_wdata[N_MIR-1:0];
      smi_q <= |(ev_q & en_hi) || |(hc_sts & en_lo);
      if (reg_rd) rd_q <= cur;
    end
  end

  assign reg_rdata = rd_q;
  assign smi_o     = smi_q;

  // R2
  bar_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bar_wr_evt |=> ev_q[N_EVT-1]);

  // R4
  sem_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (os_own_sem != sem_q) |=> ev_q[0]);

  // R9
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr_evt && reg_wr && reg_be[3] && reg_wdata[30]) |=> ev_q[1]);

  // R6
  rsv_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rd |=> (reg_rdata[28:22] == '0 && reg_rdata[12:6] == '0));

  // R7
  en_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_wr && reg_be[1]) |=> $stable(en_hi));

  // R8
  smi_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_q[N_EVT-1] && en_hi[N_EVT-1]) |=> smi_o);

  // R8
  smi_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((ev_q & en_hi) == '0 && (hc_sts & en_lo) == '0) |=> !smi_o);

endmodule

// File: tb/tb_usb_legacy_smi_reg.sv
`timescale 1ns/1ps
module tb_usb_legacy_smi_reg;
  logic clk = 0, rst_n = 0;
  logic bar_wr_evt = 0, cmd_wr_evt = 0, os_own_sem = 0;
  logic [5:0] hc_sts = 0;
  logic reg_wr = 0, reg_rd = 0;
  logic [3:0] reg_be = 0;
  logic [31:0] reg_wdata = 0;
  logic [31:0] reg_rdata;
  logic smi_o;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  usb_legacy_smi_reg dut (.*);

  // behavioural reference
  bit [2:0] m_ev; bit [2:0] m_eh; bit [5:0] m_el;
  bit m_sem, m_smi; bit [31:0] m_rd;
  always @(posedge clk) begin
    bit [2:0] nev; bit [31:0] val; bit s;
    if (!rst_n) begin
      m_ev = 0; m_eh = 0; m_el = 0; m_sem = 0; m_smi = 0; m_rd = 0;
    end else begin
      val = 0;
      val[31] = m_ev[2]; val[30] = m_ev[1]; val[29] = m_ev[0];
      for (int i = 0; i < 6; i++) val[16+i] = hc_sts[i];
      val[15] = m_eh[2]; val[14] = m_eh[1]; val[13] = m_eh[0];
      for (int i = 0; i < 6; i++) val[i] = m_el[i];
      s = 0;
      for (int i = 0; i < 3; i++) if (m_ev[i] && m_eh[i]) s = 1;
      for (int i = 0; i < 6; i++) if (hc_sts[i] && m_el[i]) s = 1;
      nev = m_ev;
      if (reg_wr && reg_be[3]) for (int i = 0; i < 3; i++) if (reg_wdata[29+i]) nev[i] = 0;
      if (bar_wr_evt) nev[2] = 1;
      if (cmd_wr_evt) nev[1] = 1;
      if (os_own_sem != m_sem) nev[0] = 1;
      if (reg_wr && reg_be[1]) m_eh = reg_wdata[15:13];
      if (reg_wr && reg_be[0]) m_el = reg_wdata[5:0];
      if (reg_rd) m_rd = val;
      m_ev = nev; m_sem = os_own_sem; m_smi = s;
    end
  end

  always @(negedge clk) if (rst_n && !done) begin
    checks += 2;
    if (smi_o !== m_smi) begin errors++; $display("FAIL R8 model smi got %0b exp %0b", smi_o, m_smi); end
    if (reg_rdata !== m_rd) begin errors++; $display("FAIL R10 model rdata got %h exp %h", reg_rdata, m_rd); end
  end

  task automatic chk(input logic [31:0] got, input logic [31:0] exp, input string tag);
    checks++;
    if (got !== exp) begin errors++; $display("FAIL %s got %h exp %h", tag, got, exp); end
  endtask

  task automatic rd(output logic [31:0] v);
    @(negedge clk) reg_rd = 1;
    @(negedge clk) reg_rd = 0; v = reg_rdata;
  endtask

  task automatic wr(input logic [3:0] be, input logic [31:0] d);
    @(negedge clk) reg_wr = 1; reg_be = be; reg_wdata = d;
    @(negedge clk) reg_wr = 0; reg_be = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    logic [31:0] v;
    idle(3); rst_n = 1; idle(1);
    rd(v); chk(v, 32'h0, "R1 reset value");
    chk({31'b0, smi_o}, 0, "R1 smi after reset");

    @(negedge clk) bar_wr_evt = 1; @(negedge clk) bar_wr_evt = 0;
    rd(v); chk(v, 32'h8000_0000, "R2 bar event");
    wr(4'h7, 32'hFFFF_0000 & 32'h8000_0000); rd(v); chk(v, 32'h8000_0000, "R2 no clear without lane3");
    wr(4'h8, 32'h8000_0000); rd(v); chk(v, 32'h0, "R2 w1c");

    @(negedge clk) cmd_wr_evt = 1; @(negedge clk) cmd_wr_evt = 0;
    rd(v); chk(v, 32'h4000_0000, "R3 cmd event");
    wr(4'h8, 32'h4000_0000); rd(v); chk(v, 32'h0, "R3 w1c");

    @(negedge clk) os_own_sem = 1; idle(1);
    rd(v); chk(v, 32'h2000_0000, "R4 sem rise");
    wr(4'h8, 32'h2000_0000); rd(v); chk(v, 32'h0, "R4 clear");
    @(negedge clk) os_own_sem = 0; idle(1);
    rd(v); chk(v, 32'h2000_0000, "R4 sem fall");
    wr(4'h8, 32'hE000_0000);

    @(negedge clk) hc_sts = 6'b100001;
    rd(v); chk(v, 32'h0021_0000, "R5 mirror");
    wr(4'h4, 32'h003F_0000); rd(v); chk(v, 32'h0021_0000, "R5 writes ignored");

    wr(4'hF, 32'hFFFF_FFFF); rd(v); chk(v, 32'h0021_E03F, "R6 reserved zero R7 enables");
    idle(1); chk({31'b0, smi_o}, 1, "R8 mirror source smi");
    @(negedge clk) hc_sts = 6'b0; idle(1);
    chk({31'b0, smi_o}, 0, "R8 smi falls");

    wr(4'h2, 32'h0); rd(v); chk(v, 32'h0000_003F, "R7 lane1 only");
    wr(4'h1, 32'hFFFF_FF15); rd(v); chk(v, 32'h0000_0015, "R7 lane0 only");

    @(negedge clk) cmd_wr_evt = 1; reg_wr = 1; reg_be = 4'h8; reg_wdata = 32'h4000_0000;
    @(negedge clk) cmd_wr_evt = 0; reg_wr = 0; reg_be = 0;
    rd(v); chk(v, 32'h4000_0015, "R9 set wins");

    wr(4'h2, 32'h0000_4000); idle(1);
    chk({31'b0, smi_o}, 1, "R8 cmd source smi");
    wr(4'h8, 32'h4000_0000); idle(1);
    chk({31'b0, smi_o}, 0, "R8 cleared");

    rd(v);
    @(negedge clk) bar_wr_evt = 1; @(negedge clk) bar_wr_evt = 0; idle(2);
    chk(reg_rdata, v, "R10 hold without strobe");
    rd(v); chk(v, 32'h8000_4015, "R10 new read");

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1; errors++; checks++;
      $display("FAIL watchdog expired got 0 exp 1");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule